// File: doc/BRIEF.md
# Configuration Port with Key Unlock

This block is the configuration front end of a multi-function I/O chip. The host reaches it through two byte-wide locations on a simple I/O bus. One is an index port and the other is a data port. After reset the block is sealed. While sealed, the only thing that counts is a fixed four-byte key written to the index port. Once the key has been seen, the host writes a register number to the index port and then reads or writes that register through the data port.

A few global registers sit at fixed indices. These are the exit register, the device selector, and the identity and revision bytes. The device selector picks which of a fixed number of per-device register banks the upper indices reach. Each bank holds an enable bit and a 16-bit I/O base address. These values leave the block as plain outputs for the devices to use. Writing a fixed code to the exit register seals the block again.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the block is sealed (cfg_open = 0), every dev_active bit is 0, every dev_base field is 0x0000, the device selector is 0 and io_rdata reads 0xFF.
- R2: The block opens only after the bytes 0x87, 0x01, 0x55, 0x55 are written to the index port (0x2E) in that order. cfg_open rises at the clock edge that samples the fourth byte.
- R3: A sealed-mode index write that does not continue the key sends the matcher back to the start. If that byte is 0x87 it counts as a new first key byte, so 0x87 0x01 0x87 0x01 0x55 0x55 opens the block.
- R4: While sealed, a read of the data port or the index port returns 0xFF, so both identity bytes read together give 0xFFFF. A data-port write changes nothing, which shows at dev_active, at dev_base and in the registers read back after opening.
- R5: While open, an index-port write sets the current index, and an index-port read returns it.
- R6: While open, a data write of 0x02 when the index is 0x02 seals the block at that edge. Any other value written to index 0x02 leaves it open.
- R7: Index 0x07 is a read/write device selector (8 bits). Its value picks the bank reached by indices 0x30, 0x60 and 0x61.
- R8: Index 0x20 reads the identity high byte and 0x21 the low byte (default 0xA5C3). Index 0x22 reads the revision in bits 3:0 (default 3) with bits 7:4 at zero.
- R9: Index 0x30 of the selected bank stores bit 0 of the written byte as that device's enable. It drives dev_active[n] and reads back as 0x00 or 0x01.
- R10: Index 0x60 holds the high byte and 0x61 the low byte of the selected device's base address. Device n's address appears on dev_base[16n+15:16n] and reads back unchanged.
- R11: When the selector is NUM_DEV or above, writes to 0x30, 0x60 and 0x61 change no output, and reads of those indices return 0x00.
- R12: io_rdata changes only at an edge that samples io_rd, and it holds otherwise. An open read of an index with no register returns 0x00. A read at any address other than the two ports returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | ADDR_W | I/O bus address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| cfg_open | output | 1 | High while configuration access is open |
| dev_active | output | NUM_DEV | Per-device enable bits |
| dev_base | output | 16*NUM_DEV | Per-device base addresses, device n in bits 16n+15:16n |

## Verification
Every write is sampled at a rising edge, and its effect on cfg_open, dev_active and dev_base shows right after that same edge. Read data lands in io_rdata at the edge that samples io_rd, so it is due one cycle after the strobe is raised. The bench drives each strobe for one cycle from a falling edge and samples at the next falling edge, half a cycle after the edge that took the access. A behavioural model advances at every rising edge and is compared with all outputs at every falling edge, and directed checks give literal expected values for the key, exit and bank corner cases.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam logic [7:0] IX_EXIT  = 8'h02;
  localparam logic [7:0] IX_LDN   = 8'h07;
  localparam logic [7:0] IX_IDHI  = 8'h20;
  localparam logic [7:0] IX_IDLO  = 8'h21;
  localparam logic [7:0] IX_REV   = 8'h22;
  localparam logic [7:0] IX_ACT   = 8'h30;
  localparam logic [7:0] IX_BASEH = 8'h60;
  localparam logic [7:0] IX_BASEL = 8'h61;

  localparam logic [7:0] EXIT_CODE = 8'h02;
  localparam logic [7:0] IDLE_BUS  = 8'hFF;
  localparam int         KEY_LEN   = 4;

  typedef enum logic [2:0] {
    KS_WAIT0,
    KS_WAIT1,
    KS_WAIT2,
    KS_WAIT3,
    KS_OPEN
  } key_state_t;

  function automatic logic [7:0] key_byte(input int pos);
    case (pos)
      0:       key_byte = 8'h87;
      1:       key_byte = 8'h01;
      default: key_byte = 8'h55;
    endcase
  endfunction

endpackage

// File: rtl/sio_cfg_unlock.sv
module sio_cfg_unlock
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       key_wr,
  input  logic [7:0] key_data,
  input  logic       exit_req,
  output logic       open
);

  key_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      KS_OPEN: if (exit_req) state_d = KS_WAIT0;
      KS_WAIT0: if (key_wr && key_data == key_byte(0)) state_d = KS_WAIT1;
      KS_WAIT1:
        if (key_wr) begin
          if (key_data == key_byte(1))      state_d = KS_WAIT2;
          else if (key_data == key_byte(0)) state_d = KS_WAIT1;
          else                              state_d = KS_WAIT0;
        end
      KS_WAIT2:
        if (key_wr) begin
          if (key_data == key_byte(2))      state_d = KS_WAIT3;
          else if (key_data == key_byte(0)) state_d = KS_WAIT1;
          else                              state_d = KS_WAIT0;
        end
      KS_WAIT3:
        if (key_wr) begin
          if (key_data == key_byte(3))      state_d = KS_OPEN;
          else if (key_data == key_byte(0)) state_d = KS_WAIT1;
          else                              state_d = KS_WAIT0;
        end
      default: state_d = KS_WAIT0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= KS_WAIT0;
    else     state_q <= state_d;
  end

  assign open = (state_q == KS_OPEN);

endmodule

// File: rtl/sio_cfg_bank.sv
module sio_cfg_bank
  import sio_cfg_pkg::*;
#(
  parameter int NUM_DEV = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [7:0]            idx,
  input  logic [7:0]            ldn,
  input  logic [7:0]            wdata,
  output logic [NUM_DEV-1:0]    dev_active,
  output logic [16*NUM_DEV-1:0] dev_base
);

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    logic        hit;
    logic        act_q;
    logic [15:0] base_q;

    assign hit = wr_en && (ldn == 8'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        act_q  <= 1'b0;
        base_q <= 16'h0000;
      end else if (hit) begin
        case (idx)
          IX_ACT:   act_q        <= wdata[0];
          IX_BASEH: base_q[15:8] <= wdata;
          IX_BASEL: base_q[7:0]  <= wdata;
          default:  ;
        endcase
      end
    end

    assign dev_active[g]         = act_q;
    assign dev_base[16*g +: 16]  = base_q;
  end

endmodule

// File: rtl/sio_cfg_rdmux.sv
module sio_cfg_rdmux
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] CHIP_ID  = 16'hA5C3,
  parameter logic [3:0]  CHIP_REV = 4'h3
) (
  input  logic [7:0]  idx,
  input  logic [7:0]  ldn,
  input  logic        sel_ok,
  input  logic        sel_act,
  input  logic [15:0] sel_base,
  output logic [7:0]  value
);

  always_comb begin
    case (idx)
      IX_LDN:   value = ldn;
      IX_IDHI:  value = CHIP_ID[15:8];
      IX_IDLO:  value = CHIP_ID[7:0];
      IX_REV:   value = {4'h0, CHIP_REV};
      IX_ACT:   value = sel_ok ? {7'h00, sel_act} : 8'h00;
      IX_BASEH: value = sel_ok ? sel_base[15:8]   : 8'h00;
      IX_BASEL: value = sel_ok ? sel_base[7:0]    : 8'h00;
      default:  value = 8'h00;
    endcase
  end

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int unsigned INDEX_PORT = 32'h2E,
  parameter int unsigned DATA_PORT  = 32'h2F,
  parameter logic [15:0] CHIP_ID    = 16'hA5C3,
  parameter logic [3:0]  CHIP_REV   = 4'h3,
  parameter int          NUM_DEV    = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     io_addr,
  input  logic                  io_wr,
  input  logic                  io_rd,
  input  logic [7:0]            io_wdata,
  output logic [7:0]            io_rdata,
  output logic                  cfg_open,
  output logic [NUM_DEV-1:0]    dev_active,
  output logic [16*NUM_DEV-1:0] dev_base
);

  localparam int SEL_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

  logic             hit_idx, hit_dat;
  logic             open;
  logic             key_wr, exit_req, cfg_wr;
  logic [7:0]       idx_q, ldn_q;
  logic             sel_ok;
  logic [SEL_W-1:0] sel;
  logic [7:0]       reg_val;
  logic [7:0]       rdata_q;

  assign hit_idx = (io_addr == ADDR_W'(INDEX_PORT));
  assign hit_dat = (io_addr == ADDR_W'(DATA_PORT));

  assign key_wr   = io_wr && hit_idx && !open;
  assign exit_req = io_wr && hit_dat && open && (idx_q == IX_EXIT) && (io_wdata == EXIT_CODE);
  assign cfg_wr   = io_wr && hit_dat && open;

  sio_cfg_unlock u_unlock (
    .clk      (clk),
    .rst      (rst),
    .key_wr   (key_wr),
    .key_data (io_wdata),
    .exit_req (exit_req),
    .open     (open)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= 8'h00;
      ldn_q <= 8'h00;
    end else begin
      if (io_wr && hit_idx && open) idx_q <= io_wdata;
      if (cfg_wr && idx_q == IX_LDN) ldn_q <= io_wdata;
    end
  end

  assign sel_ok = (int'(ldn_q) < NUM_DEV);
  assign sel    = ldn_q[SEL_W-1:0];

  sio_cfg_bank #(.NUM_DEV(NUM_DEV)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (cfg_wr),
    .idx        (idx_q),
    .ldn        (ldn_q),
    .wdata      (io_wdata),
    .dev_active (dev_active),
    .dev_base   (dev_base)
  );

  sio_cfg_rdmux #(.CHIP_ID(CHIP_ID), .CHIP_REV(CHIP_REV)) u_rdmux (
    .idx      (idx_q),
    .ldn      (ldn_q),
    .sel_ok   (sel_ok),
    .sel_act  (dev_active[sel]),
    .sel_base (dev_base[16*sel +: 16]),
    .value    (reg_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= IDLE_BUS;
    end else if (io_rd) begin
      if (hit_idx)      rdata_q <= open ? idx_q   : IDLE_BUS;
      else if (hit_dat) rdata_q <= open ? reg_val : IDLE_BUS;
      else              rdata_q <= IDLE_BUS;
    end
  end

  assign io_rdata = rdata_q;
  assign cfg_open = open;

endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter int          ADDR_W     = 16,
  parameter int unsigned INDEX_PORT = 32'h2E,
  parameter int unsigned DATA_PORT  = 32'h2F,
  parameter int          NUM_DEV    = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic [ADDR_W-1:0]     io_addr,
  input logic                  io_wr,
  input logic                  io_rd,
  input logic [7:0]            io_wdata,
  input logic [7:0]            io_rdata,
  input logic                  cfg_open,
  input logic [NUM_DEV-1:0]    dev_active,
  input logic [16*NUM_DEV-1:0] dev_base,
  input logic [7:0]            idx_q,
  input logic [7:0]            ldn_q
);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!cfg_open && dev_active == '0 && dev_base == '0 && ldn_q == 8'h00));

  // R2
  open_after_key_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_open) |-> $past(io_wr && io_addr == ADDR_W'(INDEX_PORT) && io_wdata == 8'h55));

  // R4
  sealed_read_chk: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !cfg_open && (io_addr == ADDR_W'(DATA_PORT) || io_addr == ADDR_W'(INDEX_PORT)))
      |=> io_rdata == 8'hFF);

  // R4
  sealed_write_chk: assert property (@(posedge clk) disable iff (rst)
    (io_wr && !cfg_open && io_addr == ADDR_W'(DATA_PORT))
      |=> ($stable(dev_active) && $stable(dev_base) && $stable(ldn_q)));

  // R6
  exit_seal_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_open && io_wr && io_addr == ADDR_W'(DATA_PORT) && idx_q == 8'h02 && io_wdata == 8'h02)
      |=> !cfg_open);

  // R11
  bad_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (io_wr && int'(ldn_q) >= NUM_DEV) |=> ($stable(dev_active) && $stable(dev_base)));

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !io_rd |=> $stable(io_rdata));

endmodule

bind sio_cfg_port sio_cfg_port_chk #(
  .ADDR_W     (ADDR_W),
  .INDEX_PORT (INDEX_PORT),
  .DATA_PORT  (DATA_PORT),
  .NUM_DEV    (NUM_DEV)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .io_addr    (io_addr),
  .io_wr      (io_wr),
  .io_rd      (io_rd),
  .io_wdata   (io_wdata),
  .io_rdata   (io_rdata),
  .cfg_open   (cfg_open),
  .dev_active (dev_active),
  .dev_base   (dev_base),
  .idx_q      (idx_q),
  .ldn_q      (ldn_q)
);

// File: tb/sio_cfg_port_tb.sv
module sio_cfg_port_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NDEV       = 4;
  localparam logic [15:0] IXP = 16'h002E;
  localparam logic [15:0] DTP = 16'h002F;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [15:0]       io_addr = 16'h0;
  logic              io_wr = 1'b0;
  logic              io_rd = 1'b0;
  logic [7:0]        io_wdata = 8'h0;
  logic [7:0]        io_rdata;
  logic              cfg_open;
  logic [NDEV-1:0]   dev_active;
  logic [16*NDEV-1:0] dev_base;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sio_cfg_port u_dut (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_open(cfg_open),
    .dev_active(dev_active), .dev_base(dev_base)
  );

  // behavioural reference model
  bit       m_open;
  int       m_idx, m_ldn;
  bit       m_act [NDEV];
  int       m_base[NDEV];
  int       m_rdata;
  int       hist[$];
  int       key[4] = '{'h87, 'h01, 'h55, 'h55};

  function automatic int m_reg(int ix);
    if (ix == 'h07) return m_ldn;
    if (ix == 'h20) return 'hA5;
    if (ix == 'h21) return 'hC3;
    if (ix == 'h22) return 'h03;
    if (m_ldn >= NDEV) return 0;
    if (ix == 'h30) return m_act[m_ldn] ? 1 : 0;
    if (ix == 'h60) return (m_base[m_ldn] >> 8) & 'hFF;
    if (ix == 'h61) return m_base[m_ldn] & 'hFF;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_open = 0; m_idx = 0; m_ldn = 0; m_rdata = 'hFF; hist.delete();
      foreach (m_act[i]) begin m_act[i] = 0; m_base[i] = 0; end
    end else begin
      if (io_rd) begin
        if (io_addr == IXP)      m_rdata = m_open ? m_idx : 'hFF;
        else if (io_addr == DTP) m_rdata = m_open ? m_reg(m_idx) : 'hFF;
        else                     m_rdata = 'hFF;
      end
      if (io_wr && io_addr == IXP) begin
        if (m_open) m_idx = io_wdata;
        else begin
          hist.push_back(int'(io_wdata));
          if (hist.size() > 4) void'(hist.pop_front());
          if (hist.size() == 4 && hist[0] == key[0] && hist[1] == key[1] &&
              hist[2] == key[2] && hist[3] == key[3]) begin
            m_open = 1; hist.delete();
          end
        end
      end else if (io_wr && io_addr == DTP && m_open) begin
        if (m_idx == 'h02 && io_wdata == 8'h02) begin m_open = 0; hist.delete(); end
        else if (m_idx == 'h07) m_ldn = io_wdata;
        else if (m_ldn < NDEV) begin
          if (m_idx == 'h30) m_act[m_ldn] = io_wdata[0];
          if (m_idx == 'h60) m_base[m_ldn] = (m_base[m_ldn] & 'hFF) | (int'(io_wdata) << 8);
          if (m_idx == 'h61) m_base[m_ldn] = (m_base[m_ldn] & 'hFF00) | int'(io_wdata);
        end
      end
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // compare with the model at every falling edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      logic [NDEV-1:0]    ea;
      logic [16*NDEV-1:0] eb;
      for (int i = 0; i < NDEV; i++) begin
        ea[i] = m_act[i];
        eb[16*i +: 16] = 16'(m_base[i]);
      end
      chk("R2 model cfg_open", 64'(cfg_open), 64'(m_open));
      chk("R9 model dev_active", 64'(dev_active), 64'(ea));
      chk("R10 model dev_base", 64'(dev_base), 64'(eb));
      chk("R12 model io_rdata", 64'(io_rdata), 64'(m_rdata[7:0]));
    end
  end

  task automatic wr(logic [15:0] a, logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [7:0] d);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata;
  endtask

  task automatic rreg(logic [7:0] ix, output logic [7:0] d);
    wr(IXP, ix);
    rd(DTP, d);
  endtask

  task automatic wreg(logic [7:0] ix, logic [7:0] v);
    wr(IXP, ix);
    wr(DTP, v);
  endtask

  task automatic unlock();
    wr(IXP, 8'h87); wr(IXP, 8'h01); wr(IXP, 8'h55); wr(IXP, 8'h55);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] v, hi, lo;
    logic [63:0] base_snap;
    logic [NDEV-1:0] act_snap;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1 cfg_open", 64'(cfg_open), 0);
    chk("R1 dev_active", 64'(dev_active), 0);
    chk("R1 dev_base", dev_base, 0);
    chk("R1 io_rdata", 64'(io_rdata), 64'hFF);

    // R4: sealed reads and writes
    wr(IXP, 8'h20); rd(DTP, hi);
    wr(IXP, 8'h21); rd(DTP, lo);
    chk("R4 sealed id", 64'({hi, lo}), 64'hFFFF);
    rd(IXP, v);
    chk("R4 sealed index read", 64'(v), 64'hFF);
    wr(DTP, 8'h03);
    chk("R4 sealed write outputs", 64'(dev_active), 0);

    // R3: broken key does not open
    wr(IXP, 8'h87); wr(IXP, 8'h01); wr(IXP, 8'h55); wr(IXP, 8'h11); wr(IXP, 8'h55);
    chk("R3 broken key", 64'(cfg_open), 0);
    // R3: breaking byte 0x87 restarts as first byte
    wr(IXP, 8'h87); wr(IXP, 8'h01); wr(IXP, 8'h87); wr(IXP, 8'h01); wr(IXP, 8'h55);
    chk("R2 open before last byte", 64'(cfg_open), 0);
    wr(IXP, 8'h55);
    chk("R3 restart on 0x87 opens", 64'(cfg_open), 1);

    // R5
    wr(IXP, 8'h5A); rd(IXP, v);
    chk("R5 index readback", 64'(v), 64'h5A);
    // R4: sealed data write left selector at 0
    rreg(8'h07, v);
    chk("R4 selector untouched", 64'(v), 0);
    // R8
    rreg(8'h20, hi); rreg(8'h21, lo);
    chk("R8 id", 64'({hi, lo}), 64'hA5C3);
    rreg(8'h22, v);
    chk("R8 revision", 64'(v), 64'h03);

    // R7 R9 R10: each bank
    for (int d = 0; d < NDEV; d++) begin
      wreg(8'h07, 8'(d));
      wreg(8'h30, (d % 2 == 0) ? 8'hFF : 8'hFE);
      wreg(8'h60, 8'(8'h10 + d));
      wreg(8'h61, 8'(8'h80 + d));
      rreg(8'h07, v);
      chk("R7 selector readback", 64'(v), 64'(d));
      rreg(8'h30, v);
      chk("R9 activate readback", 64'(v), (d % 2 == 0) ? 64'h1 : 64'h0);
      rreg(8'h60, hi); rreg(8'h61, lo);
      chk("R10 base readback", 64'({hi, lo}), 64'({8'(8'h10 + d), 8'(8'h80 + d)}));
    end
    chk("R9 dev_active", 64'(dev_active), 64'b0101);
    chk("R10 dev_base", dev_base, 64'h1383_1282_1181_1080);

    // R11: selector out of range
    act_snap = dev_active; base_snap = dev_base;
    wreg(8'h07, 8'(NDEV));
    wreg(8'h30, 8'h01); wreg(8'h60, 8'hEE); wreg(8'h61, 8'hDD);
    chk("R11 outputs unchanged", {base_snap == dev_base, act_snap == dev_active}, 64'h3);
    rreg(8'h30, v);
    chk("R11 activate reads zero", 64'(v), 0);
    rreg(8'h60, v);
    chk("R11 base reads zero", 64'(v), 0);

    // R12
    rreg(8'h55, v);
    chk("R12 unmapped index", 64'(v), 0);
    rreg(8'h22, v);
    repeat (3) @(negedge clk);
    chk("R12 hold without read", 64'(io_rdata), 64'h03);
    rd(16'h0300, v);
    chk("R12 other address", 64'(v), 64'hFF);

    // R6
    wreg(8'h02, 8'h05);
    chk("R6 wrong exit code", 64'(cfg_open), 1);
    wr(DTP, 8'h02);
    chk("R6 exit seals", 64'(cfg_open), 0);
    act_snap = dev_active; base_snap = dev_base;
    wr(DTP, 8'h00);
    chk("R4 sealed write after exit", {base_snap == dev_base, act_snap == dev_active}, 64'h3);
    rd(IXP, v);
    chk("R4 sealed index read after exit", 64'(v), 64'hFF);

    // re-open keeps state
    unlock();
    chk("R2 reopen", 64'(cfg_open), 1);
    rreg(8'h07, v);
    chk("R7 selector kept", 64'(v), 64'(NDEV));
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule